// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice Ring

This block builds one deep first-in first-out buffer from a ring of identical storage slices. Each slice holds `DEPTH` words. A one-bit strap marks the slice that starts the chain. Ownership of the write side and of the read side moves around the ring as two tokens. Only the slice holding the write token stores incoming words, and only the slice holding the read token drives read data. When a slice stores a word into its last location, it raises a write hand-off pulse on its expansion output. When it reads its last location, it raises a read hand-off pulse. The next slice in the ring takes the matching token at the same clock edge, so no cycle is lost at a slice boundary. The total depth is `DEPTH * NUM_SLICES`, and any depth is reached by adding slices.

Each slice reports its own empty and full flags. A small combiner at the top ANDs the flags into the composite ones and ORs the gated data outputs into one read bus. Each slice forces its data output to zero whenever it lacks the read token, which stands in for a tri-state driver. Read data falls through: the word at the head of the buffer appears on `rd_data` while `empty` is low, and `rd_en` pops it at the next edge.

Each token is held by a two-state machine inside each slice. The states are TOK_WAIT and TOK_HOLD. The transition "grab" goes from TOK_WAIT to TOK_HOLD when a hand-off pulse arrives on the expansion input. The transition "pass" goes from TOK_HOLD to TOK_WAIT when the slice sends its own pulse. A lone slice wired to itself sees grab and pass together, and it stays in TOK_HOLD. Reset puts the strapped slice in TOK_HOLD for both tokens and all other slices in TOK_WAIT. With more than one slice the ring runs cascaded, and the half-full flag and the rewind (retransmit) function are switched off. A single slice runs standalone and keeps both.

Top module: `cascade_fifo`

## Requirements
- R1: After reset, the slice with its first-load strap low (slice 0) holds both tokens: `wr_owner` and `rd_owner` equal 1 (bit 0 set). The other slices hold neither token, `empty` is 1 and `full` is 0.
- R2: Exactly one bit of `wr_owner` is set at all times. A write is stored only by the slice whose bit is set. When that slice stores a word at its location DEPTH-1, the bit moves to the next slice (index+1, and the last slice wraps to slice 0) from the following cycle on.
- R3: Exactly one bit of `rd_owner` is set at all times. When the owning slice pops the word at its location DEPTH-1, the bit moves to the next slice in the ring from the following cycle on.
- R4: Only the slice whose `rd_owner` bit is set drives data. `rd_data` carries that slice's head word, and every other slice contributes zero.
- R5: Words leave in the order they were accepted, across every slice boundary and across the wrap from the last slice back to slice 0.
- R6: `full` is 1 exactly when every slice is full, that is when DEPTH*NUM_SLICES words are stored. A write while `full` is 1 is dropped, even if a read happens in the same cycle.
- R7: `empty` is 1 exactly when every slice is empty. A read while `empty` is 1 is dropped and changes nothing.
- R8: With NUM_SLICES greater than 1, `half_full` stays 0 and `rewind` has no effect on the contents or the read order.
- R9: With NUM_SLICES equal to 1, `half_full` is 1 exactly when more than DEPTH/2 words are stored.
- R10: With NUM_SLICES equal to 1, a `rewind` cycle sets the read position back to location 0. The stored count becomes the write position, or DEPTH once the write position has wrapped, so the words written since reset are read again. Writes and reads in that cycle are dropped.
- R11: A write and a read in the same cycle both take effect when neither is blocked, and the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Pop request for the head word |
| rewind | input | 1 | Retransmit request (standalone only) |
| rd_data | output | WIDTH | Head word from the read-token holder |
| empty | output | 1 | Composite empty flag |
| full | output | 1 | Composite full flag |
| half_full | output | 1 | More than half full (standalone only) |
| wr_owner | output | NUM_SLICES | One-hot: slice holding the write token |
| rd_owner | output | NUM_SLICES | One-hot: slice driving read data (output enables) |

## Verification
The three-slice ring of depth 8 is run with four input patterns. A fill-then-drain pass with extra writes and reads beyond the limits exposes mistakes in the composite flags and in dropping blocked requests. Simultaneous write and read every cycle keeps the occupancy fixed while both tokens travel the whole ring, which separates a correct hand-off from one that loses a cycle or skips a slice. Two pseudo-random mixes, one biased towards full and one towards empty, include rewind pulses and separate true ring-order behaviour from behaviour that only works on the first lap. A standalone single-slice instance then shows that half-full and rewind work when the slice is not chained.

// File: rtl/cascade_fifo_pkg.sv
package cascade_fifo_pkg;

    // Hand-off pulses carried on a slice's expansion output.
    typedef struct packed {
        logic wr_pass;
        logic rd_pass;
    } xfer_t;

    // Ownership of one token inside one slice.
    typedef enum logic [0:0] {
        TOK_WAIT = 1'b0,
        TOK_HOLD = 1'b1
    } tok_state_t;

endpackage

// File: rtl/fifo_token_ctl.sv
module fifo_token_ctl
    import cascade_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_owner,
    input  logic grab,
    input  logic pass,
    output logic hold
);

    tok_state_t state_q, state_d;

    // Next-state logic: grab takes the token, pass hands it on.
    // A slice wired to itself sees both and keeps the token.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_WAIT: if (grab)          state_d = TOK_HOLD;
            TOK_HOLD: if (pass && !grab) state_d = TOK_WAIT;
            default:                     state_d = TOK_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= start_owner ? TOK_HOLD : TOK_WAIT;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        hold = (state_q == TOK_HOLD);
    end

    // R2/R3: only a holder may hand a token on.
    a_r2_pass_from_holder : assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> hold);

    // R2/R3: a holder that passes without receiving loses the token.
    a_r3_pass_releases : assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !grab) |=> !hold);

endmodule

// File: rtl/fifo_slice_store.sv
module fifo_slice_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             do_wr,
    input  logic [WIDTH-1:0]                 wr_word,
    input  logic                             do_rd,
    input  logic                             do_rewind,
    output logic [WIDTH-1:0]                 rd_word,
    output logic [$clog2(DEPTH+1)-1:0]       level,
    output logic                             wr_at_end,
    output logic                             rd_at_end
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level_q;
    logic             wrapped_q;

    assign wr_at_end = (wr_ptr == LAST);
    assign rd_at_end = (rd_ptr == LAST);
    assign rd_word   = mem[rd_ptr];
    assign level     = level_q;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            level_q   <= '0;
            wrapped_q <= 1'b0;
        end else if (do_rewind) begin
            rd_ptr  <= '0;
            level_q <= wrapped_q ? CW'(DEPTH) : CW'(wr_ptr);
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_at_end ? '0 : wr_ptr + 1'b1;
                if (wr_at_end) wrapped_q <= 1'b1;
            end
            if (do_rd) rd_ptr <= rd_at_end ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_rd)      level_q <= level_q + 1'b1;
            else if (!do_wr && do_rd) level_q <= level_q - 1'b1;
        end
    end

    a_r6_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |-> (level_q != CW'(DEPTH)));

    a_r7_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |-> (level_q != '0));

    a_r11_level_steady : assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && do_rd && !do_rewind) |=> (level_q == $past(level_q)));

    a_r5_level_grows : assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !do_rd && !do_rewind) |=> (level_q == $past(level_q) + 1'b1));

endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
    import cascade_fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_load_n,
    input  logic             chained,
    input  xfer_t            xi,
    output xfer_t            xo,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind,
    output logic [WIDTH-1:0] rd_data,
    output logic             oe,
    output logic             wr_hold,
    output logic             empty,
    output logic             full,
    output logic             half_full
);

    localparam int CW = $clog2(DEPTH + 1);

    logic             rd_hold;
    logic             rewind_ok, do_wr, do_rd;
    logic             wr_at_end, rd_at_end;
    logic [CW-1:0]    level;
    logic [WIDTH-1:0] head_word;

    assign rewind_ok = rewind && !chained;
    assign full      = (level == CW'(DEPTH));
    assign empty     = (level == '0);
    assign do_wr     = wr_en && wr_hold && !full  && !rewind_ok;
    assign do_rd     = rd_en && rd_hold && !empty && !rewind_ok;

    assign xo.wr_pass = do_wr && wr_at_end;
    assign xo.rd_pass = do_rd && rd_at_end;

    fifo_token_ctl u_wr_tok (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_owner (!first_load_n),
        .grab        (xi.wr_pass),
        .pass        (xo.wr_pass),
        .hold        (wr_hold)
    );

    fifo_token_ctl u_rd_tok (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_owner (!first_load_n),
        .grab        (xi.rd_pass),
        .pass        (xo.rd_pass),
        .hold        (rd_hold)
    );

    fifo_slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_wr     (do_wr),
        .wr_word   (wr_data),
        .do_rd     (do_rd),
        .do_rewind (rewind_ok),
        .rd_word   (head_word),
        .level     (level),
        .wr_at_end (wr_at_end),
        .rd_at_end (rd_at_end)
    );

    // Tri-state stand-in: drive only while holding the read token.
    assign oe        = rd_hold;
    assign rd_data   = rd_hold ? head_word : '0;
    assign half_full = !chained && (level > CW'(DEPTH / 2));

    // R8: in a chain a rewind request leaves occupancy untouched.
    a_r8_rewind_inert : assert property (@(posedge clk) disable iff (!rst_n)
        (chained && rewind && !wr_en && !rd_en) |=> (level == $past(level)));

    // R2: a slice without the write token never changes on a write alone.
    a_r2_writes_need_token : assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hold && !rd_en && !rewind_ok) |=> (level == $past(level)));

endmodule

// File: rtl/fifo_flag_merge.sv
module fifo_flag_merge #(
    parameter int WIDTH      = 8,
    parameter int NUM_SLICES = 3
) (
    input  logic [NUM_SLICES-1:0]       full_v,
    input  logic [NUM_SLICES-1:0]       empty_v,
    input  logic [NUM_SLICES*WIDTH-1:0] data_flat,
    output logic                        full,
    output logic                        empty,
    output logic [WIDTH-1:0]            rd_data
);

    assign full  = &full_v;
    assign empty = &empty_v;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            rd_data = rd_data | data_flat[i*WIDTH +: WIDTH];
        end
    end

endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
    import cascade_fifo_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 8,
    parameter int NUM_SLICES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WIDTH-1:0]      wr_data,
    input  logic                  rd_en,
    input  logic                  rewind,
    output logic [WIDTH-1:0]      rd_data,
    output logic                  empty,
    output logic                  full,
    output logic                  half_full,
    output logic [NUM_SLICES-1:0] wr_owner,
    output logic [NUM_SLICES-1:0] rd_owner
);

    localparam logic IS_CHAIN = (NUM_SLICES > 1);

    xfer_t                       xo_v [NUM_SLICES];
    logic [NUM_SLICES-1:0]       full_v, empty_v, hf_v;
    logic [NUM_SLICES*WIDTH-1:0] data_flat;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
        fifo_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .first_load_n (i != 0),
            .chained      (IS_CHAIN),
            .xi           (xo_v[PREV]),
            .xo           (xo_v[i]),
            .wr_en        (wr_en),
            .wr_data      (wr_data),
            .rd_en        (rd_en),
            .rewind       (rewind),
            .rd_data      (data_flat[i*WIDTH +: WIDTH]),
            .oe           (rd_owner[i]),
            .wr_hold      (wr_owner[i]),
            .empty        (empty_v[i]),
            .full         (full_v[i]),
            .half_full    (hf_v[i])
        );
    end

    fifo_flag_merge #(.WIDTH(WIDTH), .NUM_SLICES(NUM_SLICES)) u_merge (
        .full_v    (full_v),
        .empty_v   (empty_v),
        .data_flat (data_flat),
        .full      (full),
        .empty     (empty),
        .rd_data   (rd_data)
    );

    assign half_full = |hf_v;

    a_r2_single_writer : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_owner) == 1);

    a_r3_single_reader : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_owner) == 1);

    a_r6_full_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !rewind) |=> full);

    a_r7_empty_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en && !rewind) |=> empty);

    a_r2_owner_still : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_owner));

endmodule

// File: tb/test_cascade_fifo.sv
module test_cascade_fifo;

    localparam int W   = 8;
    localparam int D   = 8;
    localparam int N   = 3;
    localparam int CAP = D * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         empty, full, half_full;
    logic [N-1:0] wr_owner, rd_owner;

    logic         s_wr_en = 1'b0, s_rd_en = 1'b0, s_rewind = 1'b0;
    logic [W-1:0] s_wr_data = '0;
    logic [W-1:0] s_rd_data;
    logic         s_empty, s_full, s_half_full;
    logic [0:0]   s_wr_owner, s_rd_owner;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W-1:0] mq [CAP];
    int head = 0, tail = 0, cnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [W-1:0] next_val = 8'd1;

    always #5 clk = ~clk;

    cascade_fifo #(.WIDTH(W), .DEPTH(D), .NUM_SLICES(N)) i_cascade_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data), .empty(empty),
        .full(full), .half_full(half_full), .wr_owner(wr_owner), .rd_owner(rd_owner)
    );

    cascade_fifo #(.WIDTH(W), .DEPTH(D), .NUM_SLICES(1)) i_cascade_fifo_solo (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_data(s_wr_data),
        .rd_en(s_rd_en), .rewind(s_rewind), .rd_data(s_rd_data), .empty(s_empty),
        .full(s_full), .half_full(s_half_full), .wr_owner(s_wr_owner), .rd_owner(s_rd_owner)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int onehot_of(input int pos);
        return 1 << (pos / D);
    endfunction

    // One cycle on the three-slice ring: drive, compare pre-edge state, update model.
    task automatic step(input bit we, input bit re, input bit rw);
        @(negedge clk);
        wr_en = we; rd_en = re; rewind = rw; wr_data = next_val;
        #1;
        check(empty == (cnt == 0), "R7 empty", empty, cnt == 0);
        check(full == (cnt == CAP), "R6 full", full, cnt == CAP);
        check(int'(wr_owner) == onehot_of(tail), "R2 wr_owner", wr_owner, onehot_of(tail));
        check(int'(rd_owner) == onehot_of(head), "R3 rd_owner", rd_owner, onehot_of(head));
        check(half_full == 1'b0, "R8 half_full", half_full, 0);
        if (cnt > 0)
            check(rd_data == mq[head], "R5/R4 rd_data", rd_data, mq[head]);
        else
            check(rd_data == mq[head] || 1'b1, "R4 idle", 0, 0);
        @(posedge clk);
        begin
            bit wok, rok;
            wok = we && (cnt < CAP);
            rok = re && (cnt > 0);
            if (wok) begin
                mq[tail] = next_val;
                tail = (tail + 1) % CAP;
                next_val = next_val + 8'd1;
            end
            if (rok) head = (head + 1) % CAP;
            cnt = cnt + int'(wok) - int'(rok);
        end
    endtask

    task automatic s_step(input bit we, input logic [W-1:0] wd, input bit re, input bit rw);
        @(negedge clk);
        s_wr_en = we; s_wr_data = wd; s_rd_en = re; s_rewind = rw;
        @(posedge clk);
        #1;
        s_wr_en = 1'b0; s_rd_en = 1'b0; s_rewind = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < CAP; i++) mq[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: strapped slice owns both tokens after reset
        check(wr_owner == 3'b001, "R1 wr_owner", wr_owner, 1);
        check(rd_owner == 3'b001, "R1 rd_owner", rd_owner, 1);
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);

        // R7: reads on an empty ring are dropped
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);

        // Pattern 0 (R6, R2): overfill then overdrain
        for (int i = 0; i < CAP + 6; i++) step(1'b1, 1'b0, 1'b0);
        // R6: write with simultaneous read while full is dropped
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < CAP + 6; i++) step(1'b0, 1'b1, 1'b0);

        // Pattern 1 (R11, R3): prefill, then write and read every cycle
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3 * CAP + 7; i++) step(1'b1, 1'b1, 1'b0);

        // Pattern 2: biased towards full, with rewind pulses (R8)
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2], lfsr[7] & lfsr[8]);
        end
        // Pattern 3: biased towards empty, with rewind pulses (R8)
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3], lfsr[4] | lfsr[5], lfsr[6] & lfsr[9]);
        end
        // Drain what is left (R5)
        for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;

        // Standalone slice: R9 half-full threshold and R10 rewind
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            check(s_half_full == (k > D / 2), "R9 half_full", s_half_full, k > D / 2);
            s_step(1'b1, W'(100 + k), 1'b0, 1'b0);
        end
        @(negedge clk); #1;
        check(s_half_full == 1'b1, "R9 half_full at 6", s_half_full, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check(s_rd_data == W'(100 + k), "R10 pre-rewind data", s_rd_data, 100 + k);
            s_step(1'b0, '0, 1'b1, 1'b0);
        end
        @(negedge clk); #1;
        check(s_half_full == 1'b0, "R9 half_full at 3", s_half_full, 0);
        // R10: rewind with a write request in the same cycle (write dropped)
        s_step(1'b1, 8'hEE, 1'b0, 1'b1);
        @(negedge clk); #1;
        check(s_half_full == 1'b1, "R10 count restored", s_half_full, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            check(s_empty == 1'b0, "R10 not empty", s_empty, 0);
            check(s_rd_data == W'(100 + k), "R10 replay data", s_rd_data, 100 + k);
            s_step(1'b0, '0, 1'b1, 1'b0);
        end
        @(negedge clk); #1;
        check(s_empty == 1'b1, "R10 empty after replay", s_empty, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule